// File: doc/BRIEF.md
# Effective Address Quadrant Qualifier

This block sits at the front of an address-translation pipeline. Each request carries a 64-bit effective address, a flag telling whether the requester runs at hypervisor privilege, the access kind (instruction fetch, data load or data store), and the current values of the partition-ID and process-ID registers. The block decides which partition ID and process ID the translation will use, or it rejects the address with a segment fault.

The two most significant address bits form a quadrant number that picks the (partition, process) pair. The mapping depends on privilege: a hypervisor may reach all four quadrants, each with its own mix of the live registers and zero, while a guest may only use quadrants 0 and 3. A second field of ten reserved address bits must be all zero. Any violation becomes a segment fault. A fetch fault is reported as an instruction segment fault. A load or store fault is reported as a data segment fault, and the faulting address is kept in a fault-address register.

The answer is registered and appears one cycle after the request, together with a one-cycle valid strobe. The error code that goes with any fault is zero.

Top module: `ea_quadrant_qualifier`

## Requirements
- R1: While reset is asserted and on the first cycle after it is released, rsp_valid, rsp_ok, rsp_iseg and rsp_dseg are 0, and fault_addr is 0.
- R2: A request with any nonzero bit in the reserved field, ea[61:52], is a segment fault (rsp_ok = 0) for every quadrant and privilege.
- R3: With hv = 1 and a clean reserved field, quadrant 0 (ea[63:62] = 2'b00) gives partition 0 with the process register, and quadrant 1 (2'b01) gives the partition register with the process register.
- R4: With hv = 1 and a clean reserved field, quadrant 2 (2'b10) gives the partition register with process 0, and quadrant 3 (2'b11) gives partition 0 with process 0.
- R5: With hv = 0 and a clean reserved field, quadrant 0 gives the partition register with the process register, and quadrant 3 gives the partition register with process 0.
- R6: With hv = 0, quadrants 1 and 2 are a segment fault.
- R7: A fault on an access of kind 2'b00 (fetch) sets rsp_iseg, leaves rsp_dseg at 0 and leaves fault_addr unchanged.
- R8: A fault on an access of kind 2'b01 (load), 2'b10 (store) or 2'b11 (handled as a load) sets rsp_dseg, leaves rsp_iseg at 0 and loads the request address into fault_addr.
- R9: rsp_err_code is zero on every cycle, including on faults.
- R10: rsp_valid is 1 exactly in the cycle after a cycle with req_valid = 1. When rsp_valid is 1, exactly one of rsp_ok, rsp_iseg and rsp_dseg is 1; when it is 0, all three are 0. On a fault, rsp_lpid and rsp_pid are 0.
- R11: fault_addr keeps its value through successful requests, fetch faults and idle cycles, and changes only on a data segment fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A request is present this cycle |
| req_ea | input | 64 | Effective address |
| req_hv | input | 1 | 1 = hypervisor privilege, 0 = guest |
| req_kind | input | 2 | Access kind: 00 fetch, 01 load, 10 store, 11 load |
| lpid_reg | input | LPID_W (12) | Current partition-ID register |
| pid_reg | input | PID_W (20) | Current process-ID register |
| rsp_valid | output | 1 | One-cycle strobe; the result is present |
| rsp_ok | output | 1 | The address qualified without fault |
| rsp_lpid | output | LPID_W (12) | Qualified partition ID |
| rsp_pid | output | PID_W (20) | Qualified process ID |
| rsp_iseg | output | 1 | Instruction segment fault |
| rsp_dseg | output | 1 | Data segment fault |
| rsp_err_code | output | ERR_W (16) | Error code for the fault, always zero |
| fault_addr | output | 64 | Address of the most recent data segment fault |

## Verification
The properties assume that req_hv, req_kind, req_ea and both ID registers are stable and known in every cycle where req_valid is high. The properties compare each result against those inputs as sampled one edge earlier. The bench drives every input on the falling clock edge and holds it until the next falling edge. It chooses random addresses whose reserved field is mostly clean, so that the quadrant mapping is exercised far more often than the reserved-field fault. It adds idle gaps and directed cases for every quadrant under both privileges with every access kind.

// File: rtl/eaq_pkg.sv
package eaq_pkg;
  // Access kind codes on req_kind
  localparam logic [1:0] KIND_FETCH = 2'b00;
  localparam logic [1:0] KIND_LOAD  = 2'b01;
  localparam logic [1:0] KIND_STORE = 2'b10;
  localparam logic [1:0] KIND_ALT   = 2'b11;  // handled as a data load

  typedef enum logic [1:0] {
    QUAD_0 = 2'b00,
    QUAD_1 = 2'b01,
    QUAD_2 = 2'b10,
    QUAD_3 = 2'b11
  } quad_e;

  // Source chosen for each qualified ID
  typedef struct packed {
    logic use_lpid_reg;
    logic use_pid_reg;
    logic legal;
  } quad_sel_t;
endpackage

// File: rtl/eaq_rsv_check.sv
module eaq_rsv_check #(
  parameter int W = 10
) (
  input  logic [W-1:0] field,
  output logic         nonzero
);
  logic [W:0] chain;
  assign chain[0] = 1'b0;
  for (genvar i = 0; i < W; i++) begin : g_or
    assign chain[i+1] = chain[i] | field[i];
  end
  assign nonzero = chain[W];
endmodule

// File: rtl/eaq_quad_map.sv
module eaq_quad_map
  import eaq_pkg::*;
#(
  parameter int LPID_W = 12,
  parameter int PID_W  = 20
) (
  input  logic [1:0]        quadrant,
  input  logic              hv,
  input  logic [LPID_W-1:0] lpid_reg,
  input  logic [PID_W-1:0]  pid_reg,
  output logic              legal,
  output logic [LPID_W-1:0] lpid,
  output logic [PID_W-1:0]  pid
);
  quad_sel_t sel;

  always_comb begin
    sel = '0;
    if (hv) begin
      unique case (quad_e'(quadrant))
        QUAD_0: sel = '{use_lpid_reg: 1'b0, use_pid_reg: 1'b1, legal: 1'b1};
        QUAD_1: sel = '{use_lpid_reg: 1'b1, use_pid_reg: 1'b1, legal: 1'b1};
        QUAD_2: sel = '{use_lpid_reg: 1'b1, use_pid_reg: 1'b0, legal: 1'b1};
        QUAD_3: sel = '{use_lpid_reg: 1'b0, use_pid_reg: 1'b0, legal: 1'b1};
        default: sel = '0;
      endcase
    end else begin
      unique case (quad_e'(quadrant))
        QUAD_0: sel = '{use_lpid_reg: 1'b1, use_pid_reg: 1'b1, legal: 1'b1};
        QUAD_3: sel = '{use_lpid_reg: 1'b1, use_pid_reg: 1'b0, legal: 1'b1};
        default: sel = '0;
      endcase
    end
  end

  assign legal = sel.legal;
  assign lpid  = sel.use_lpid_reg ? lpid_reg : '0;
  assign pid   = sel.use_pid_reg  ? pid_reg  : '0;
endmodule

// File: rtl/eaq_fault_class.sv
module eaq_fault_class
  import eaq_pkg::*;
(
  input  logic       fault,
  input  logic [1:0] kind,
  output logic       iseg,
  output logic       dseg
);
  logic is_fetch;
  assign is_fetch = (kind == KIND_FETCH);
  assign iseg = fault &  is_fetch;
  assign dseg = fault & ~is_fetch;
endmodule

// File: rtl/ea_quadrant_qualifier.sv
module ea_quadrant_qualifier #(
  parameter int EA_W   = 64,
  parameter int LPID_W = 12,
  parameter int PID_W  = 20,
  parameter int RSV_HI = 61,
  parameter int RSV_LO = 52,
  parameter int ERR_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [EA_W-1:0]   req_ea,
  input  logic              req_hv,
  input  logic [1:0]        req_kind,
  input  logic [LPID_W-1:0] lpid_reg,
  input  logic [PID_W-1:0]  pid_reg,
  output logic              rsp_valid,
  output logic              rsp_ok,
  output logic [LPID_W-1:0] rsp_lpid,
  output logic [PID_W-1:0]  rsp_pid,
  output logic              rsp_iseg,
  output logic              rsp_dseg,
  output logic [ERR_W-1:0]  rsp_err_code,
  output logic [EA_W-1:0]   fault_addr
);
  localparam int Q_HI  = EA_W - 1;
  localparam int Q_LO  = EA_W - 2;
  localparam int RSV_W = RSV_HI - RSV_LO + 1;

  logic              rsv_bad;
  logic              q_legal;
  logic [LPID_W-1:0] map_lpid;
  logic [PID_W-1:0]  map_pid;
  logic              fault;
  logic              iseg_c, dseg_c;

  eaq_rsv_check #(.W(RSV_W)) u_rsv (
    .field   (req_ea[RSV_HI:RSV_LO]),
    .nonzero (rsv_bad)
  );

  eaq_quad_map #(.LPID_W(LPID_W), .PID_W(PID_W)) u_map (
    .quadrant (req_ea[Q_HI:Q_LO]),
    .hv       (req_hv),
    .lpid_reg (lpid_reg),
    .pid_reg  (pid_reg),
    .legal    (q_legal),
    .lpid     (map_lpid),
    .pid      (map_pid)
  );

  assign fault = req_valid & (rsv_bad | ~q_legal);

  eaq_fault_class u_cls (
    .fault (fault),
    .kind  (req_kind),
    .iseg  (iseg_c),
    .dseg  (dseg_c)
  );

  // Next-state
  logic              valid_d, ok_d, iseg_d, dseg_d;
  logic [LPID_W-1:0] lpid_d;
  logic [PID_W-1:0]  pid_d;
  logic              id_en, fa_en;
  logic [EA_W-1:0]   fa_d;

  always_comb begin
    valid_d = req_valid;
    ok_d    = req_valid & ~fault;
    iseg_d  = iseg_c;
    dseg_d  = dseg_c;
    id_en   = req_valid;
    lpid_d  = fault ? '0 : map_lpid;
    pid_d   = fault ? '0 : map_pid;
    fa_en   = dseg_c;
    fa_d    = req_ea;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_ok    <= 1'b0;
      rsp_iseg  <= 1'b0;
      rsp_dseg  <= 1'b0;
    end else begin
      rsp_valid <= valid_d;
      rsp_ok    <= ok_d;
      rsp_iseg  <= iseg_d;
      rsp_dseg  <= dseg_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_lpid <= '0;
      rsp_pid  <= '0;
    end else if (id_en) begin
      rsp_lpid <= lpid_d;
      rsp_pid  <= pid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_addr <= '0;
    end else if (fa_en) begin
      fault_addr <= fa_d;
    end
  end

  assign rsp_err_code = '0;
endmodule

// File: rtl/eaq_checker.sv
module eaq_checker #(
  parameter int EA_W   = 64,
  parameter int LPID_W = 12,
  parameter int PID_W  = 20,
  parameter int RSV_HI = 61,
  parameter int RSV_LO = 52
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [EA_W-1:0]   req_ea,
  input logic              req_hv,
  input logic [1:0]        req_kind,
  input logic [LPID_W-1:0] lpid_reg,
  input logic [PID_W-1:0]  pid_reg,
  input logic              rsp_valid,
  input logic              rsp_ok,
  input logic [LPID_W-1:0] rsp_lpid,
  input logic [PID_W-1:0]  rsp_pid,
  input logic              rsp_iseg,
  input logic              rsp_dseg,
  input logic [EA_W-1:0]   fault_addr
);
  logic [1:0] quad;
  logic       clean;
  assign quad  = req_ea[EA_W-1:EA_W-2];
  assign clean = (req_ea[RSV_HI:RSV_LO] == '0);

  a_r10_strobe_follows: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  a_r10_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  a_r10_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $countones({rsp_ok, rsp_iseg, rsp_dseg}) == 1);
  a_r10_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> !(rsp_ok | rsp_iseg | rsp_dseg));
  a_r2_reserved_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !clean) |=> !rsp_ok);
  a_r3_hv_quad0: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_hv && clean && quad == 2'b00) |=>
      (rsp_ok && rsp_lpid == '0 && rsp_pid == $past(pid_reg)));
  a_r4_hv_quad3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_hv && clean && quad == 2'b11) |=>
      (rsp_ok && rsp_lpid == '0 && rsp_pid == '0));
  a_r5_guest_quad0: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_hv && clean && quad == 2'b00) |=>
      (rsp_ok && rsp_lpid == $past(lpid_reg) && rsp_pid == $past(pid_reg)));
  a_r6_guest_illegal: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_hv && (quad == 2'b01 || quad == 2'b10)) |=> !rsp_ok);
  a_r7_fetch_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ok && $past(req_kind) == 2'b00) |-> rsp_iseg);
  a_r8_data_capture: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_dseg |-> fault_addr == $past(req_ea));
  a_r11_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_dseg |-> $stable(fault_addr));
endmodule

bind ea_quadrant_qualifier eaq_checker #(
  .EA_W(EA_W), .LPID_W(LPID_W), .PID_W(PID_W), .RSV_HI(RSV_HI), .RSV_LO(RSV_LO)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ea(req_ea),
  .req_hv(req_hv), .req_kind(req_kind), .lpid_reg(lpid_reg), .pid_reg(pid_reg),
  .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_lpid(rsp_lpid), .rsp_pid(rsp_pid),
  .rsp_iseg(rsp_iseg), .rsp_dseg(rsp_dseg), .fault_addr(fault_addr)
);

// File: tb/tb_ea_quadrant_qualifier.sv
module tb_ea_quadrant_qualifier;
  localparam int CLK_PERIOD = 10;
  localparam int LPID_W = 12;
  localparam int PID_W  = 20;
  localparam int WATCHDOG = 20000;

  logic              clk;
  logic              rst_n;
  logic              req_valid;
  logic [63:0]       req_ea;
  logic              req_hv;
  logic [1:0]        req_kind;
  logic [LPID_W-1:0] lpid_reg;
  logic [PID_W-1:0]  pid_reg;
  logic              rsp_valid, rsp_ok, rsp_iseg, rsp_dseg;
  logic [LPID_W-1:0] rsp_lpid;
  logic [PID_W-1:0]  rsp_pid;
  logic [15:0]       rsp_err_code;
  logic [63:0]       fault_addr;

  int checks = 0;
  int fails  = 0;
  logic [63:0] exp_fa;
  bit done = 0;

  ea_quadrant_qualifier dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ea(req_ea),
    .req_hv(req_hv), .req_kind(req_kind), .lpid_reg(lpid_reg), .pid_reg(pid_reg),
    .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_lpid(rsp_lpid), .rsp_pid(rsp_pid),
    .rsp_iseg(rsp_iseg), .rsp_dseg(rsp_dseg), .rsp_err_code(rsp_err_code),
    .fault_addr(fault_addr)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Model: returns {legal, lpid, pid}
  function automatic logic [LPID_W+PID_W:0] model(input logic [63:0] ea, input logic hv,
      input logic [LPID_W-1:0] lp, input logic [PID_W-1:0] pd);
    logic [1:0] q;
    q = ea[63:62];
    if (ea[61:52] != 10'd0) return '0;            // R2
    if (hv) begin
      case (q)
        2'b00: return {1'b1, {LPID_W{1'b0}}, pd}; // R3
        2'b01: return {1'b1, lp, pd};             // R3
        2'b10: return {1'b1, lp, {PID_W{1'b0}}};  // R4
        default: return {1'b1, {LPID_W{1'b0}}, {PID_W{1'b0}}}; // R4
      endcase
    end
    case (q)
      2'b00: return {1'b1, lp, pd};               // R5
      2'b11: return {1'b1, lp, {PID_W{1'b0}}};    // R5
      default: return '0;                          // R6
    endcase
  endfunction

  function automatic string map_tag(input logic [63:0] ea, input logic hv);
    if (ea[61:52] != 10'd0) return "R2";
    if (!hv) return (ea[63:62] == 2'b01 || ea[63:62] == 2'b10) ? "R6" : "R5";
    return (ea[63:62] == 2'b00 || ea[63:62] == 2'b01) ? "R3" : "R4";
  endfunction

  // Drive one request at negedge, check at the following negedge
  task automatic issue(input logic [63:0] ea, input logic hv, input logic [1:0] kind);
    logic [LPID_W+PID_W:0] e;
    logic legal;
    string t;
    req_valid = 1'b1; req_ea = ea; req_hv = hv; req_kind = kind;
    e = model(ea, hv, lpid_reg, pid_reg);
    legal = e[LPID_W+PID_W];
    t = map_tag(ea, hv);
    @(negedge clk);
    req_valid = 1'b0;
    check("R10 valid", {63'd0, rsp_valid}, 64'd1);
    check({t, " ok"}, {63'd0, rsp_ok}, {63'd0, legal});
    check({t, " lpid"}, {52'd0, rsp_lpid}, {52'd0, e[LPID_W+PID_W-1:PID_W]});
    check({t, " pid"}, {44'd0, rsp_pid}, {44'd0, e[PID_W-1:0]});
    check("R7 iseg", {63'd0, rsp_iseg}, {63'd0, !legal && kind == 2'b00});
    check("R8 dseg", {63'd0, rsp_dseg}, {63'd0, !legal && kind != 2'b00});
    if (!legal && kind != 2'b00) exp_fa = ea;
    check("R11 R8 fault_addr", fault_addr, exp_fa);
    check("R9 err code", {48'd0, rsp_err_code}, 64'd0);
  endtask

  task automatic idle();
    @(negedge clk);
    check("R10 idle", {61'd0, rsp_valid, rsp_ok, rsp_iseg | rsp_dseg}, 64'd0);
    check("R11 idle hold", fault_addr, exp_fa);
  endtask

  function automatic logic [63:0] rnd_ea();
    logic [63:0] ea;
    ea = {$urandom, $urandom};
    if (($urandom % 4) != 0) ea[61:52] = '0;
    return ea;
  endfunction

  initial begin
    void'($urandom(32'h5eed_1234));
    rst_n = 1'b0; req_valid = 1'b0; req_ea = '0; req_hv = 1'b0; req_kind = 2'b00;
    lpid_reg = 12'hA5C; pid_reg = 20'h3_1F07;
    exp_fa = '0;
    repeat (3) @(negedge clk);
    check("R1 reset flags", {60'd0, rsp_valid, rsp_ok, rsp_iseg, rsp_dseg}, 64'd0);
    check("R1 reset fault_addr", fault_addr, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", {60'd0, rsp_valid, rsp_ok, rsp_iseg, rsp_dseg}, 64'd0);
    check("R1 fault_addr after release", fault_addr, 64'd0);

    // Directed: every quadrant, both privileges, all kinds
    for (int h = 0; h < 2; h++)
      for (int q = 0; q < 4; q++)
        for (int k = 0; k < 4; k++)
          issue({q[1:0], 10'd0, 52'h0_1234_5678_9ABC} ^ {12'd0, 52'(k)}, h[0], k[1:0]);
    // Reserved-field edges: lowest and highest reserved bit
    issue(64'hC010_0000_0000_0040, 1'b1, 2'b01);   // bit 52, R2
    issue(64'h2000_0000_0000_0080, 1'b0, 2'b00);   // bit 61, R2 fetch
    issue(64'hC00F_FFFF_FFFF_FFFF, 1'b0, 2'b10);   // clean, guest q3
    // Fetch fault after data fault leaves fault_addr alone
    issue(64'h4000_0000_0000_1000, 1'b0, 2'b10);   // R6 data
    issue(64'h8000_0000_0000_2000, 1'b0, 2'b00);   // R6 fetch, R7
    idle();
    issue(64'h0000_0000_0000_3000, 1'b0, 2'b01);   // ok, R11
    // Back-to-back with changing ID registers
    for (int i = 0; i < 400; i++) begin
      lpid_reg = LPID_W'($urandom);
      pid_reg  = PID_W'($urandom);
      issue(rnd_ea(), 1'($urandom), 2'($urandom));
      if (($urandom % 5) == 0) idle();
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int c = 0; c < WATCHDOG; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule